// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit ports, called A and B, and moves data between them in either direction. Each direction owns a capture register with its own clock and its own synchronous reset. A per-direction source select decides whether the port being driven shows live data taken from the other port in the same cycle, or the value held in that direction's register. An active-low output enable and a direction input decide which port is driven, if either is.

Each port is split into an input vector, an output vector and a single output-enable bit, so the block has no internal tri-states. The pad ring merges each triple into a real bidirectional pin. Capture continues while both outputs are off. A system can therefore load both registers in isolation and release them onto the bus later. A build-time parameter inverts both data paths.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst_ab` low, the A-direction register loads `a_in`, which is 8 bits wide.
- R2: On each rising edge of `clk_ba` with `rst_ba` low, the B-direction register loads `b_in`. An edge of `clk_ab` never changes this register, and an edge of `clk_ba` never changes the A-direction register.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R4: While `oe_n` is 0, `dir` = 1 drives port B only (`b_oe` = 1, `a_oe` = 0), and `dir` = 0 drives port A only (`a_oe` = 1, `b_oe` = 0). `a_oe` and `b_oe` are never 1 together.
- R5: `b_out` equals `a_in` in the same cycle when `sel_ab` = 0, and equals the A-direction register when `sel_ab` = 1. This holds whatever the enables are.
- R6: `a_out` equals `b_in` in the same cycle when `sel_ba` = 0, and equals the B-direction register when `sel_ba` = 1. This holds whatever the enables are.
- R7: With `oe_n` = 1, clock edges still load both registers.
- R8: While one port is driven, the other port's input is both passed through live and captured by its clock edge.
- R9: With parameter `INVERT` = 1, `a_out` and `b_out` are the bitwise complement of the source chosen under R5 and R6. The registers hold the uninverted value.
- R10: A rising edge of `clk_ab` with `rst_ab` high clears only the A-direction register to zero. A rising edge of `clk_ba` with `rst_ba` high clears only the B-direction register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-direction register |
| rst_ab | input | 1 | Synchronous active-high clear of the A-direction register |
| clk_ba | input | 1 | Capture clock of the B-direction register |
| rst_ba | input | 1 | Synchronous active-high clear of the B-direction register |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: A drives B, 0: B drives A |
| sel_ab | input | 1 | Source for port B: 0 live, 1 stored |
| sel_ba | input | 1 | Source for port A: 0 live, 1 stored |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Value offered to port A |
| a_oe | output | 1 | Drive enable of port A |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Value offered to port B |
| b_oe | output | 1 | Drive enable of port B |

## Verification
The bench sweeps all sixteen combinations of `oe_n`, `dir`, `sel_ab` and `sel_ba` over a set of data patterns. The patterns include all-zeros, all-ones, alternating bits, single edge bits and computed values. A and B always carry different data, so a swapped path or a stuck bit shows up as a mismatch. Outputs are checked before and after each capture. The pre-capture view separates live data from stored data. The post-capture view shows whether the load happened in isolation or while the other port was driven. Further steps pulse one clock at a time, and clear one register at a time, to show the two directions are independent. A second instance built with inversion on runs through the same vectors against complemented expectations.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1/R2: a clock edge outside reset loads the port value
  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q == $past(d));

  // R10: a reset edge leaves the register at zero
  assert_clear_R10: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

// File: rtl/path_select.sv
module path_select
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  src_e             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] chosen;

  always_comb begin
    if (sel == SRC_STORED) chosen = stored;
    else                   chosen = live;
  end

  generate
    if (INVERT) begin : g_inv
      assign y = ~chosen;
    end else begin : g_pass
      assign y = chosen;
    end
  endgenerate

endmodule

// File: rtl/drive_decode.sv
module drive_decode
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_t en
);

  always_comb begin
    en = '0;
    if (!oe_n) begin
      if (dir) en.b_en = 1'b1;
      else     en.a_en = 1'b1;
    end
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk_ab,
  input  logic              rst_ab,
  input  logic              clk_ba,
  input  logic              rst_ba,
  input  logic              oe_n,
  input  logic              dir,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe
);

  logic [DATA_W-1:0] held_a;
  logic [DATA_W-1:0] held_b;
  drive_t            drv;

  capture_reg #(.WIDTH(DATA_W)) u_reg_a (
    .clk (clk_ab),
    .rst (rst_ab),
    .d   (a_in),
    .q   (held_a)
  );

  capture_reg #(.WIDTH(DATA_W)) u_reg_b (
    .clk (clk_ba),
    .rst (rst_ba),
    .d   (b_in),
    .q   (held_b)
  );

  path_select #(.WIDTH(DATA_W), .INVERT(INVERT)) u_to_b (
    .sel    (src_e'(sel_ab)),
    .live   (a_in),
    .stored (held_a),
    .y      (b_out)
  );

  path_select #(.WIDTH(DATA_W), .INVERT(INVERT)) u_to_a (
    .sel    (src_e'(sel_ba)),
    .live   (b_in),
    .stored (held_b),
    .y      (a_out)
  );

  drive_decode u_dec (
    .oe_n (oe_n),
    .dir  (dir),
    .en   (drv)
  );

  assign a_oe = drv.a_en;
  assign b_oe = drv.b_en;

  always_comb begin
    if (!$isunknown({oe_n, dir, a_oe, b_oe})) begin
      assert_single_driver_R4: assert (!(a_oe && b_oe));
      if (oe_n) begin
        assert_isolated_R3: assert (!a_oe && !b_oe);
      end else begin
        assert_dir_select_R4: assert (b_oe == dir && a_oe == !dir);
      end
    end
  end

endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  localparam int W        = 8;
  localparam int CLK_HALF = 5;

  logic         clk_ab = 0, clk_ba = 0, rst_ab = 0, rst_ba = 0;
  logic         oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, a_out_i, b_out_i;
  logic         a_oe, b_oe, a_oe_i, b_oe_i;

  int           n_vec = 0, n_bad = 0;
  logic [W-1:0] m_a = '0, m_b = '0;

  regbus_xcvr #(.DATA_W(W), .INVERT(1'b0)) u_dut (
    .clk_ab(clk_ab), .rst_ab(rst_ab), .clk_ba(clk_ba), .rst_ba(rst_ba),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  regbus_xcvr #(.DATA_W(W), .INVERT(1'b1)) u_dut_inv (
    .clk_ab(clk_ab), .rst_ab(rst_ab), .clk_ba(clk_ba), .rst_ba(rst_ba),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out_i), .a_oe(a_oe_i),
    .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i));

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    logic         ea, eb;
    logic [W-1:0] xb, xa;
    string        req;
    ea  = !oe_n && !dir;
    eb  = !oe_n && dir;
    req = oe_n ? "R3" : "R4";
    chk({req, " a_oe ", ctx}, {7'b0, a_oe}, {7'b0, ea});
    chk({req, " b_oe ", ctx}, {7'b0, b_oe}, {7'b0, eb});
    chk({req, " inv a_oe ", ctx}, {7'b0, a_oe_i}, {7'b0, ea});
    chk({req, " inv b_oe ", ctx}, {7'b0, b_oe_i}, {7'b0, eb});
    chk({"R4 single driver ", ctx}, {7'b0, a_oe & b_oe}, '0);
    xb = sel_ab ? m_a : a_in;
    xa = sel_ba ? m_b : b_in;
    chk({"R5 b_out ", ctx}, b_out, xb);
    chk({"R6 a_out ", ctx}, a_out, xa);
    chk({"R9 inverted b_out ", ctx}, b_out_i, ~xb);
    chk({"R9 inverted a_out ", ctx}, a_out_i, ~xa);
  endtask

  task automatic pulse_ab();
    #CLK_HALF clk_ab = 1;
    m_a = rst_ab ? '0 : a_in;
    #CLK_HALF clk_ab = 0;
  endtask

  task automatic pulse_ba();
    #CLK_HALF clk_ba = 1;
    m_b = rst_ba ? '0 : b_in;
    #CLK_HALF clk_ba = 0;
  endtask

  function automatic logic [W-1:0] pat(int p);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      3: return 8'h5A;
      4: return 8'h01;
      5: return 8'h80;
      default: return W'(p * 53);
    endcase
  endfunction

  initial begin
    #(CLK_HALF * 2 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R10: clear both registers while inputs carry ones
    rst_ab = 1; rst_ba = 1; a_in = 8'hFF; b_in = 8'hFF;
    pulse_ab(); pulse_ba();
    rst_ab = 0; rst_ba = 0;
    oe_n = 1; sel_ab = 1; sel_ba = 1;
    #1 check_all("R10 reset state");

    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 16; c++) begin
        oe_n   = c[0];
        dir    = c[1];
        sel_ab = c[2];
        sel_ba = c[3];
        a_in   = pat(p) ^ W'(c * 17);
        b_in   = {a_in[3:0], a_in[7:4]} ^ 8'h3C ^ W'(p);
        #1 check_all("before capture");
        pulse_ab();
        pulse_ba();
        #1 check_all(oe_n ? "R7 R1 R2 isolated capture"
                          : "R8 R1 R2 capture while driving");
      end
    end

    // R2: each clock touches only its own register
    oe_n = 0; dir = 1; sel_ab = 1; sel_ba = 1;
    a_in = 8'h3C; b_in = 8'hC3;
    pulse_ab();
    #1 check_all("R2 only A clock");
    a_in = 8'h99; b_in = 8'h66;
    pulse_ba();
    #1 check_all("R2 only B clock");

    // R10: reset of one side leaves the other intact
    rst_ab = 1; pulse_ab(); rst_ab = 0;
    #1 check_all("R10 A clear only");
    chk("R10 A register zero", b_out, 8'h00);
    chk("R10 B register kept", a_out, 8'h66);
    rst_ba = 1; pulse_ba(); rst_ba = 0;
    #1 check_all("R10 B clear only");
    chk("R10 B register zero", a_out, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule